// File: doc/BRIEF.md
# Calendar Alarm Matcher with Repeat Selection

This block watches a running calendar, presented as five fields (second, minute, hour, day of month, month), and raises an alarm when those fields equal a set of programmed alarm values. A five-bit repeat code picks how many of the fields take part in the comparison. The comparison runs from the least significant field upward, so the alarm can fire every second, every minute, every hour, every day, every month or once a year. The comparison is made only on a cycle where the time source pulses its update strobe. A single matching second therefore sets the flag once.

When a match occurs, a sticky alarm flag is set. An active-low interrupt line follows the flag when the interrupt enable is set. While the system runs in backup mode, the interrupt also needs a second enable. A read strobe on the flags register clears both the flag and the interrupt. The reader still sees the flag as set during the read cycle itself. Software programs the alarm fields, the repeat code and the two enables through a small register write port.

Control is a three-state machine:
- `ST_OFF`: the alarm is disabled because both the alarm day field and the repeat code are zero.
- `ST_IDLE`: the alarm is armed and the flag is clear.
- `ST_HELD`: the flag is set.

The transitions are:
- *arm*: `ST_OFF` to `ST_IDLE`, taken when the configuration becomes non-disabled.
- *disarm*: `ST_IDLE` to `ST_OFF`.
- *match*: `ST_OFF` or `ST_IDLE` to `ST_HELD`, taken on a hit.
- *rematch*: `ST_HELD` stays in `ST_HELD` on a hit.
- *acknowledge*: `ST_HELD` to `ST_IDLE`, or to `ST_OFF` if the alarm is disabled, taken on a flags read with no hit in the same cycle.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, `alarm_flag` is 0 and `irq_n` is 1. All alarm fields, the repeat code and both enables are 0, so the alarm starts disabled.
- R2: The repeat code is held in register 5, bits [4:0]. The codes select the compared fields as follows:
  - 5'b11111 compares no field, so the alarm fires every strobe.
  - 5'b11110 compares the second.
  - 5'b11100 compares the second and minute.
  - 5'b11000 compares the second, minute and hour.
  - 5'b10000 compares the second, minute, hour and day.
  - 5'b00000 compares all five fields.
- R3: Any repeat code not listed in R2 behaves like 5'b11111 and fires on every strobe.
- R4: A hit is an `upd_stb` cycle in which all compared fields are equal. A hit sets `alarm_flag` from the next cycle on. Without a strobe, the flag is never set, even when the fields are equal.
- R5: `irq_n` is 0 exactly when `alarm_flag` is 1 and the interrupt enable (register 6 bit 0) is 1, subject to R8. Otherwise `irq_n` is 1.
- R6: A cycle with `flag_rd` high and no hit leaves `alarm_flag` visible in that cycle. From the next cycle, `alarm_flag` is 0 and `irq_n` is 1.
- R7: When a hit and `flag_rd` fall in the same cycle, the hit wins and `alarm_flag` stays 1 afterwards.
- R8: While `backup` is 1, `irq_n` can go low only if the backup enable (register 6 bit 1) is also 1. The flag itself is set regardless of `backup`.
- R9: When the alarm day register and the repeat code are both 0, strobes never set the flag. This holds even when every time field equals its alarm field.
- R10: The write port takes effect at the clock edge of a `wr_en` cycle. The addresses are: 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 repeat code, 6 enables. Address 7 has no effect. A comparison in the write cycle uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_stb | input | 1 | One-cycle pulse: time fields were updated |
| cur_sec | input | FIELD_W | Current second |
| cur_min | input | FIELD_W | Current minute |
| cur_hour | input | FIELD_W | Current hour |
| cur_date | input | FIELD_W | Current day of month |
| cur_mon | input | FIELD_W | Current month |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (R10) |
| wr_data | input | FIELD_W | Register write data |
| flag_rd | input | 1 | Flags register read strobe |
| backup | input | 1 | System is in backup mode |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt request; 1 when released |

## Verification
The two functions that can share a cycle are setting the flag on a match and clearing it on a flags read. The bench provokes this by pulsing `upd_stb` with matching fields and `flag_rd` on the same clock. It then expects the flag to survive (R7), followed by a plain read that clears it. A second collision places a register write on the same edge as a comparison. The behavioural reference model expects the comparison to use the pre-write values and flags every clock on which the design disagrees.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int NFIELD = 5;
    localparam int RPT_W  = 5;

    localparam logic [2:0] AD_RPT = 3'd5;
    localparam logic [2:0] AD_CTL = 3'd6;
    localparam int DAY_IDX = 3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_HELD = 2'd2
    } alm_state_e;

    // Maps the repeat code to a compare mask; bit 0 = second ... bit 4 = month.
    function automatic logic [NFIELD-1:0] rpt_to_mask(input logic [RPT_W-1:0] code);
        logic [NFIELD-1:0] m;
        case (code)
            5'b11111: m = 5'b00000;
            5'b11110: m = 5'b00001;
            5'b11100: m = 5'b00011;
            5'b11000: m = 5'b00111;
            5'b10000: m = 5'b01111;
            5'b00000: m = 5'b11111;
            default:  m = 5'b00000; // unlisted: fire every strobe
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_addr,
    input  logic [FIELD_W-1:0]              wr_data,
    output logic [NFIELD-1:0][FIELD_W-1:0]  alm_val,
    output logic [RPT_W-1:0]                rpt,
    output logic                            int_en,
    output logic                            bk_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_val <= '0;
            rpt     <= '0;
            int_en  <= 1'b0;
            bk_en   <= 1'b0;
        end else if (wr_en) begin
            for (int i = 0; i < NFIELD; i++) begin
                if (wr_addr == 3'(i)) alm_val[i] <= wr_data;
            end
            if (wr_addr == AD_RPT) rpt <= wr_data[RPT_W-1:0];
            if (wr_addr == AD_CTL) begin
                int_en <= wr_data[0];
                bk_en  <= wr_data[1];
            end
        end
    end

endmodule

// File: rtl/alm_compare.sv
module alm_compare
    import alm_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic                            upd_stb,
    input  logic [NFIELD-1:0][FIELD_W-1:0]  cur_t,
    input  logic [NFIELD-1:0][FIELD_W-1:0]  alm_val,
    input  logic [RPT_W-1:0]                rpt,
    output logic                            hit,
    output logic                            disabled
);

    logic [NFIELD-1:0] mask;
    logic [NFIELD-1:0] eq;

    assign mask = rpt_to_mask(rpt);

    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
        assign eq[i] = !mask[i] || (cur_t[i] == alm_val[i]);
    end

    assign disabled = (alm_val[DAY_IDX] == '0) && (rpt == '0);
    assign hit      = upd_stb && !disabled && (&eq);

endmodule

// File: rtl/alm_ctrl.sv
module alm_ctrl
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic disabled,
    input  logic flag_rd,
    input  logic int_en,
    input  logic bk_en,
    input  logic backup,
    output logic alarm_flag,
    output logic irq_n
);

    alm_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (hit)            state_nx = ST_HELD;  // match
                else if (!disabled) state_nx = ST_IDLE;  // arm
            end
            ST_IDLE: begin
                if (hit)           state_nx = ST_HELD;   // match
                else if (disabled) state_nx = ST_OFF;    // disarm
            end
            ST_HELD: begin
                if (hit)          state_nx = ST_HELD;    // rematch wins over read
                else if (flag_rd) state_nx = disabled ? ST_OFF : ST_IDLE; // acknowledge
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        alarm_flag = (state == ST_HELD);
        irq_n      = !(alarm_flag && int_en && (!backup || bk_en));
    end

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
    import alm_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_stb,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_date,
    input  logic [FIELD_W-1:0] cur_mon,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               flag_rd,
    input  logic               backup,
    output logic               alarm_flag,
    output logic               irq_n
);

    logic [NFIELD-1:0][FIELD_W-1:0] cur_t;
    logic [NFIELD-1:0][FIELD_W-1:0] alm_val;
    logic [RPT_W-1:0]               rpt;
    logic                           int_en;
    logic                           bk_en;
    logic                           hit;
    logic                           disabled;

    assign cur_t = {cur_mon, cur_date, cur_hour, cur_min, cur_sec};

    alm_regs #(.FIELD_W(FIELD_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .alm_val (alm_val),
        .rpt     (rpt),
        .int_en  (int_en),
        .bk_en   (bk_en)
    );

    alm_compare #(.FIELD_W(FIELD_W)) u_cmp (
        .upd_stb  (upd_stb),
        .cur_t    (cur_t),
        .alm_val  (alm_val),
        .rpt      (rpt),
        .hit      (hit),
        .disabled (disabled)
    );

    alm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .disabled   (disabled),
        .flag_rd    (flag_rd),
        .int_en     (int_en),
        .bk_en      (bk_en),
        .backup     (backup),
        .alarm_flag (alarm_flag),
        .irq_n      (irq_n)
    );

endmodule

// File: rtl/alm_match_chk.sv
module alm_match_chk (
    input logic clk,
    input logic rst_n,
    input logic upd_stb,
    input logic flag_rd,
    input logic backup,
    input logic alarm_flag,
    input logic irq_n,
    input logic hit,
    input logic disabled,
    input logic int_en,
    input logic bk_en
);

    p_hit_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> alarm_flag);

    p_no_strobe_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !upd_stb) |=> !alarm_flag);

    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (alarm_flag && int_en));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !hit) |=> (!alarm_flag && irq_n));

    p_collide_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && hit) |=> alarm_flag);

    p_backup_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (backup && !bk_en) |-> irq_n);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disabled |-> !hit);

endmodule

bind alarm_match_unit alm_match_chk u_chk (.*);

// File: tb/sim_alarm_match_unit.sv
`timescale 1ns/1ps
module sim_alarm_match_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_mon = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       flag_rd = 1'b0;
    logic       backup = 1'b0;
    logic       alarm_flag, irq_n;

    always #10 clk = ~clk; // 50 MHz

    alarm_match_unit u0 (.*);

    int    checks = 0;
    int    errors = 0;
    string req = "R1";

    // behavioural reference state
    int m_reg[7];
    bit m_flag = 0;
    bit started = 0;
    bit m_hit;
    int m_used;
    int m_cur[5];

    function automatic int fields_used(int code);
        case (code)
            31: return 0;
            30: return 1;
            28: return 2;
            24: return 3;
            16: return 4;
            0:  return 5;
            default: return 0; // R3
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0;
            for (int i = 0; i < 7; i++) m_reg[i] = 0;
        end else begin
            m_cur[0] = cur_sec; m_cur[1] = cur_min; m_cur[2] = cur_hour;
            m_cur[3] = cur_date; m_cur[4] = cur_mon;
            m_used = fields_used(m_reg[5]);
            m_hit = upd_stb && !(m_reg[3] == 0 && m_reg[5] == 0);
            for (int i = 0; i < m_used; i++) if (m_cur[i] != m_reg[i]) m_hit = 0;
            if (m_hit) m_flag = 1;
            else if (flag_rd) m_flag = 0;
            if (wr_en) begin
                if (wr_addr < 5)       m_reg[wr_addr] = wr_data;
                else if (wr_addr == 5) m_reg[5] = wr_data & 31;
                else if (wr_addr == 6) m_reg[6] = wr_data & 3;
            end
        end
        started = 1;
    end

    task automatic check_bit(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_irq_n();
        return !(m_flag && (m_reg[6] & 1) != 0 && (!backup || (m_reg[6] & 2) != 0));
    endfunction

    // cycle-by-cycle compare, away from the edge
    always @(negedge clk) begin
        if (started) begin
            #5;
            check_bit("model alarm_flag", alarm_flag, m_flag);
            check_bit("model irq_n", irq_n, exp_irq_n());
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic tick(input logic [7:0] s, mi, h, d, mo, input bit rd);
        @(negedge clk);
        cur_sec = s; cur_min = mi; cur_hour = h; cur_date = d; cur_mon = mo;
        upd_stb = 1; flag_rd = rd;
        @(negedge clk); upd_stb = 0; flag_rd = 0;
    endtask

    task automatic rd_flags();
        @(negedge clk); flag_rd = 1;
        @(negedge clk); flag_rd = 0;
    endtask

    task automatic expect_flag(logic e, logic ei);
        #3;
        check_bit("directed alarm_flag", alarm_flag, e);
        check_bit("directed irq_n", irq_n, ei);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        req = "R1";
        repeat (3) @(negedge clk);
        expect_flag(0, 1);
        rst_n = 1;
        @(negedge clk); expect_flag(0, 1);

        req = "R10";
        wr(0, 8'h30); wr(1, 8'h15); wr(2, 8'h08); wr(3, 8'h12); wr(4, 8'h05);
        wr(5, 8'h00); wr(6, 8'h01);
        wr(7, 8'hFF);

        req = "R2";  // yearly: month differs -> no hit
        tick(8'h30, 8'h15, 8'h08, 8'h12, 8'h04, 0); expect_flag(0, 1);
        req = "R4";
        tick(8'h30, 8'h15, 8'h08, 8'h12, 8'h05, 0); expect_flag(1, 0);
        req = "R6";
        rd_flags(); expect_flag(0, 1);
        req = "R4";  // equal fields but no strobe
        @(negedge clk); cur_sec = 8'h30; cur_min = 8'h15; cur_hour = 8'h08;
        cur_date = 8'h12; cur_mon = 8'h05;
        repeat (3) @(negedge clk);
        expect_flag(0, 1);

        req = "R2";  // monthly
        wr(5, 8'h10);
        tick(8'h30, 8'h15, 8'h08, 8'h12, 8'h09, 0); expect_flag(1, 0);
        rd_flags();
        tick(8'h30, 8'h15, 8'h08, 8'h13, 8'h05, 0); expect_flag(0, 1);
        wr(5, 8'h18);  // daily
        tick(8'h30, 8'h15, 8'h08, 8'h01, 8'h01, 0); expect_flag(1, 0);
        rd_flags();
        tick(8'h30, 8'h15, 8'h09, 8'h12, 8'h05, 0); expect_flag(0, 1);
        wr(5, 8'h1C);  // hourly
        tick(8'h30, 8'h15, 8'h22, 8'h01, 8'h01, 0); expect_flag(1, 0);
        rd_flags();
        tick(8'h30, 8'h16, 8'h08, 8'h12, 8'h05, 0); expect_flag(0, 1);
        wr(5, 8'h1E);  // per minute
        tick(8'h30, 8'h44, 8'h22, 8'h01, 8'h01, 0); expect_flag(1, 0);
        rd_flags();
        tick(8'h31, 8'h15, 8'h08, 8'h12, 8'h05, 0); expect_flag(0, 1);
        wr(5, 8'h1F);  // per second
        tick(8'h01, 8'h02, 8'h03, 8'h04, 8'h06, 0); expect_flag(1, 0);
        rd_flags(); expect_flag(0, 1);

        req = "R3";
        wr(5, 8'h15);
        tick(8'h01, 8'h02, 8'h03, 8'h04, 8'h06, 0); expect_flag(1, 0);
        rd_flags();
        wr(5, 8'h01);
        tick(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 0); expect_flag(1, 0);
        rd_flags(); expect_flag(0, 1);

        req = "R5";
        wr(6, 8'h00);
        tick(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 0); expect_flag(1, 1);
        wr(6, 8'h01); expect_flag(1, 0);
        rd_flags(); expect_flag(0, 1);

        req = "R8";
        @(negedge clk); backup = 1;
        tick(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 0); expect_flag(1, 1);
        wr(6, 8'h03); expect_flag(1, 0);
        rd_flags(); expect_flag(0, 1);
        @(negedge clk); backup = 0;

        req = "R7";
        tick(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 0);
        tick(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 1); expect_flag(1, 0);
        rd_flags(); expect_flag(0, 1);

        req = "R10";  // write and compare on the same edge use old repeat code
        wr(5, 8'h00);
        @(negedge clk);
        cur_sec = 8'h00; cur_min = 8'h00; cur_hour = 8'h00; cur_date = 8'h01; cur_mon = 8'h01;
        upd_stb = 1; wr_en = 1; wr_addr = 5; wr_data = 8'h1F;
        @(negedge clk); upd_stb = 0; wr_en = 0; expect_flag(0, 1);

        req = "R9";
        wr(3, 8'h00); wr(5, 8'h00);
        tick(8'h30, 8'h15, 8'h08, 8'h00, 8'h05, 0); expect_flag(0, 1);
        tick(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0); expect_flag(0, 1);

        req = "R2";  // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            upd_stb = ($urandom_range(0, 2) == 0);
            flag_rd = ($urandom_range(0, 5) == 0);
            backup  = ($urandom_range(0, 3) == 0);
            cur_sec = 8'($urandom_range(0, 1)); cur_min = 8'($urandom_range(0, 1));
            cur_hour = 8'($urandom_range(0, 1)); cur_date = 8'($urandom_range(0, 1));
            cur_mon = 8'($urandom_range(0, 1));
            wr_en = ($urandom_range(0, 7) == 0);
            wr_addr = 3'($urandom_range(0, 7));
            case ($urandom_range(0, 3))
                0: wr_data = 8'h1F;
                1: wr_data = 8'h10;
                2: wr_data = 8'h00;
                default: wr_data = 8'($urandom_range(0, 3));
            endcase
        end
        @(negedge clk); upd_stb = 0; flag_rd = 0; wr_en = 0;
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule